// File: doc/BRIEF.md
# Coprocessor Bus Channel Bridge

This block sits between a processor bus and a hardware coprocessor and carries messages over up to eight two-way channels. Every transfer is started by the processor: a bus write places a word into a channel's inbound queue, and a bus read takes a word from a channel's outbound queue or returns the fill state of one of the channel's two queues. One 16-bit address selects all of it. The high byte names the target coprocessor. Bits 7:5 pick the channel. Bit 3 separates message data from status. Bit 4 picks which status word is returned. The low three bits must carry the code that marks coprocessor address space.

On the core side, each channel offers its inbound queue as a valid/ready source and accepts words for its outbound queue as a valid/ready sink. A source holds its word stable while ready is low. A sink stalls the producer by dropping ready when its queue is full. The queue depth, the data width, the channel count and the coprocessor number are parameters.

Top module: `cpbus_chan_bridge`

## Requirements
- R1: An access is claimed only when address bits 15:8 equal COPRO_ID, bits 2:0 equal 3'b001 and bits 7:5 name a channel below NUM_CH. An unclaimed access pushes nothing, pops nothing and leaves bus_rdata at zero.
- R2: A strobe with bus_rnw low and address bit 3 low pushes bus_wdata into the inbound queue of the channel given by bits 7:5.
- R3: A strobe with bus_rnw high and address bit 3 low pops the head of the addressed outbound queue. That word appears on bus_rdata in the cycle after the strobe.
- R4: A strobe with bus_rnw high and address bit 3 high returns a status word and pops nothing. Bit 4 = 0 selects the inbound queue and bit 4 = 1 selects the outbound queue. In the status word, bit 0 is empty, bit 1 is full and all other bits are zero.
- R5: A write to a full inbound queue is dropped, and the words already stored stay intact and in order.
- R6: A data read from an empty outbound queue returns zero and leaves the queue unchanged.
- R7: An access takes place only in the cycle where bus_mreq AND bus_breq rises. Holding both strobes high produces exactly one push or pop.
- R8: bus_rdata is zero in every cycle that does not directly follow a claimed read.
- R9: core_in_valid of a channel is high while its inbound queue holds a word, and core_in_data shows the oldest word. The word leaves the queue on a cycle with valid and ready both high. While ready is low, valid and data hold steady.
- R10: core_out_ready of a channel is high while its outbound queue is not full. A word is taken on a cycle with valid and ready both high, and bus reads return such words in arrival order.
- R11: A write with address bit 3 high is ignored.
- R12: After reset every queue is empty, bus_rdata is zero, every core_in_valid is low and every core_out_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address: target number, channel, status select, data/status, space code |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_mreq | input | 1 | Memory request strobe |
| bus_breq | input | 1 | Bus request strobe |
| bus_wdata | input | DATA_W | Write data from the processor |
| bus_rdata | output | DATA_W | Registered read data, zero when idle |
| core_in_valid | output | NUM_CH | Inbound queue holds a word, one bit per channel |
| core_in_ready | input | NUM_CH | Core accepts the inbound word |
| core_in_data | output | NUM_CH*DATA_W | Oldest inbound word; channel c is in slice c*DATA_W |
| core_out_valid | input | NUM_CH | Core offers an outbound word |
| core_out_ready | output | NUM_CH | Outbound queue has room |
| core_out_data | input | NUM_CH*DATA_W | Outbound words; channel c is in slice c*DATA_W |

## Verification
Read results, both data and status, appear on bus_rdata one cycle after the clock edge that samples the rising strobe. A bus write shows on core_in_valid and core_in_data one cycle after that edge. A core handshake or a bus pop shows on the ready, valid and status outputs one cycle later. The driver stamps each expected read word with the cycle in which it is due. A monitor samples bus_rdata on the falling edge of that cycle and requires zero on every other falling edge. Core-side outputs are compared on the falling edge after the edge that moved them.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

  // code in the low address bits that marks coprocessor space
  localparam logic [2:0] SPACE_CODE = 3'b001;
  // the address field carries three channel bits
  localparam int CH_SLOTS = 8;

  // field layout of the bus address, most significant first
  typedef struct packed {
    logic [7:0] copro;
    logic [2:0] chan;
    logic       stat_sel;
    logic       is_stat;
    logic [2:0] space;
  } bus_addr_t;

  typedef enum logic {
    Q_INBOUND  = 1'b0,
    Q_OUTBOUND = 1'b1
  } qsel_e;

endpackage

// File: rtl/cpbus_fifo.sv
module cpbus_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CAP);
  assign head_o  = mem[rd_ptr];

  // a full queue refuses the push even when a pop happens in the same cycle
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(rd_ptr)));

  a_r6_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (empty_o && $stable(rd_ptr)));

endmodule

// File: rtl/cpbus_decode.sv
module cpbus_decode
  import cpbus_pkg::*;
#(
  parameter logic [7:0] COPRO_ID = 8'h5A,
  parameter int         NUM_CH   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_rnw,
  input  logic        bus_mreq,
  input  logic        bus_breq,
  output logic        wr_fire,
  output logic        rd_fire,
  output logic        stat_fire,
  output qsel_e       stat_q,
  output logic [2:0]  chan
);

  localparam logic [3:0] CH_LIMIT = 4'(NUM_CH);

  bus_addr_t fields;
  logic      req, req_q, strobe, hit;

  assign fields = bus_addr_t'(bus_addr);
  assign req    = bus_mreq && bus_breq;

  // only the rising edge of the combined request counts as an access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign strobe = req && !req_q;
  assign hit    = (fields.copro == COPRO_ID) && (fields.space == SPACE_CODE)
                  && ({1'b0, fields.chan} < CH_LIMIT);

  assign chan      = fields.chan;
  assign stat_q    = qsel_e'(fields.stat_sel);
  assign wr_fire   = strobe && hit && !bus_rnw && !fields.is_stat;
  assign rd_fire   = strobe && hit &&  bus_rnw && !fields.is_stat;
  assign stat_fire = strobe && hit &&  bus_rnw &&  fields.is_stat;

  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || rd_fire || stat_fire) |=> !(wr_fire || rd_fire || stat_fire));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_fire, rd_fire, stat_fire}));

endmodule

// File: rtl/cpbus_chan_bridge.sv
module cpbus_chan_bridge
  import cpbus_pkg::*;
#(
  parameter logic [7:0] COPRO_ID   = 8'h5A,
  parameter int         NUM_CH     = 8,
  parameter int         DATA_W     = 16,
  parameter int         FIFO_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              bus_addr,
  input  logic                     bus_rnw,
  input  logic                     bus_mreq,
  input  logic                     bus_breq,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_CH-1:0]        core_in_valid,
  input  logic [NUM_CH-1:0]        core_in_ready,
  output logic [NUM_CH*DATA_W-1:0] core_in_data,
  input  logic [NUM_CH-1:0]        core_out_valid,
  output logic [NUM_CH-1:0]        core_out_ready,
  input  logic [NUM_CH*DATA_W-1:0] core_out_data
);

  logic        wr_fire, rd_fire, stat_fire;
  qsel_e       stat_q;
  logic [2:0]  chan;

  logic [CH_SLOTS-1:0] in_empty, in_full, out_empty, out_full;
  logic [DATA_W-1:0]   out_head [CH_SLOTS];

  cpbus_decode #(
    .COPRO_ID (COPRO_ID),
    .NUM_CH   (NUM_CH)
  ) decode_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rnw   (bus_rnw),
    .bus_mreq  (bus_mreq),
    .bus_breq  (bus_breq),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .stat_fire (stat_fire),
    .stat_q    (stat_q),
    .chan      (chan)
  );

  for (genvar g = 0; g < CH_SLOTS; g++) begin : g_ch
    if (g < NUM_CH) begin : g_live
      logic [DATA_W-1:0] in_head;

      cpbus_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) inq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (wr_fire && (chan == 3'(g))),
        .push_data_i (bus_wdata),
        .pop_i       (core_in_ready[g]),
        .head_o      (in_head),
        .empty_o     (in_empty[g]),
        .full_o      (in_full[g])
      );

      cpbus_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) outq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (core_out_valid[g]),
        .push_data_i (core_out_data[g*DATA_W +: DATA_W]),
        .pop_i       (rd_fire && (chan == 3'(g))),
        .head_o      (out_head[g]),
        .empty_o     (out_empty[g]),
        .full_o      (out_full[g])
      );

      assign core_in_valid[g]                   = !in_empty[g];
      assign core_in_data[g*DATA_W +: DATA_W]   = in_head;
      assign core_out_ready[g]                  = !out_full[g];

      a_r9_source_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_in_valid[g] && !core_in_ready[g])
          |=> (core_in_valid[g] && $stable(core_in_data[g*DATA_W +: DATA_W])));
    end else begin : g_idle
      // slots beyond NUM_CH look permanently empty and are never addressed
      assign in_empty[g]  = 1'b1;
      assign in_full[g]   = 1'b0;
      assign out_empty[g] = 1'b1;
      assign out_full[g]  = 1'b0;
      assign out_head[g]  = '0;
    end
  end

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rd_fire) begin
      rd_next = out_empty[chan] ? '0 : out_head[chan];
    end else if (stat_fire) begin
      if (stat_q == Q_INBOUND) rd_next[1:0] = {in_full[chan], in_empty[chan]};
      else                     rd_next[1:0] = {out_full[chan], out_empty[chan]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire || stat_fire) |=> (bus_rdata == '0));

  a_r4_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire |=> (bus_rdata[DATA_W-1:2] == '0));

  a_r4_status_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire |=> $stable(out_empty));

endmodule

// File: tb/cpbus_chan_bridge_tb.sv
`timescale 1ns/1ps
module cpbus_chan_bridge_tb_top;

  localparam int         W  = 16;
  localparam int         N  = 8;
  localparam int         D  = 8;
  localparam logic [7:0] ID = 8'h5A;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [15:0]    bus_addr = '0;
  logic           bus_rnw = 1'b0, bus_mreq = 1'b0, bus_breq = 1'b0;
  logic [W-1:0]   bus_wdata = '0;
  logic [W-1:0]   bus_rdata;
  logic [N-1:0]   core_in_valid, core_in_ready = '0;
  logic [N*W-1:0] core_in_data;
  logic [N-1:0]   core_out_valid = '0, core_out_ready;
  logic [N*W-1:0] core_out_data = '0;

  int  checks = 0, errors = 0, cyc = 0;
  bit  run = 0, done = 0;

  typedef struct {
    logic [W-1:0] v;
    int           due;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpbus_chan_bridge #(.COPRO_ID(ID), .NUM_CH(N), .DATA_W(W), .FIFO_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_mreq(bus_mreq), .bus_breq(bus_breq), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_in_data(core_in_data),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
    .core_out_data(core_out_data)
  );

  function automatic logic [15:0] mk(logic [7:0] id, int ch, bit st, bit sel,
                                     logic [2:0] sp = 3'b001);
    return {id, 3'(ch), sel, st, sp};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: due words are compared, all other cycles must read zero (R8)
  always @(negedge clk) begin
    if (run) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, 32'(bus_rdata), 32'(e.v));
      end else begin
        chk("R8 idle rdata", 32'(bus_rdata), 32'h0);
      end
    end
  end

  // driver: called at a falling edge; holds the strobes for 'hold' cycles
  task automatic bus_op(logic [15:0] a, bit rnw, logic [W-1:0] wd, int hold,
                        logic [W-1:0] exp, string tag);
    for (int i = 0; i < hold; i++) begin
      bus_addr = a; bus_rnw = rnw; bus_wdata = wd;
      bus_mreq = 1'b1; bus_breq = 1'b1;
      if (rnw) sb.push_back('{(i == 0) ? exp : '0, cyc + 1, tag});
      @(negedge clk);
    end
    bus_mreq = 1'b0; bus_breq = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain_one(int ch, logic [W-1:0] exp, string tag);
    chk({tag, " valid"}, 32'(core_in_valid[ch]), 32'h1);
    chk({tag, " data"}, 32'(core_in_data[ch*W +: W]), 32'(exp));
    core_in_ready[ch] = 1'b1;
    @(negedge clk);
    core_in_ready[ch] = 1'b0;
  endtask

  task automatic core_push(int ch, logic [W-1:0] d);
    chk("R10 ready before push", 32'(core_out_ready[ch]), 32'h1);
    core_out_valid[ch] = 1'b1;
    core_out_data[ch*W +: W] = d;
    @(negedge clk);
    core_out_valid[ch] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R12 actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rdata", 32'(bus_rdata), 32'h0);
    chk("R12 in_valid", 32'(core_in_valid), 32'h0);
    chk("R12 out_ready", 32'(core_out_ready), 32'hFF);
    run = 1;

    // R2 / R9: three writes to channel 2, then drain in order
    bus_op(mk(ID, 2, 0, 0), 0, 16'h1111, 1, '0, "");
    chk("R2 in_valid after write", 32'(core_in_valid[2]), 32'h1);
    bus_op(mk(ID, 2, 0, 0), 0, 16'h2222, 1, '0, "");
    bus_op(mk(ID, 2, 0, 0), 0, 16'h3333, 1, '0, "");
    bus_op(mk(ID, 2, 1, 0), 1, '0, 1, 16'h0000, "R4 inbound status busy");
    bus_op(mk(ID, 2, 1, 1), 1, '0, 1, 16'h0001, "R4 outbound status empty");
    repeat (2) @(negedge clk);
    chk("R9 hold data", 32'(core_in_data[2*W +: W]), 32'h1111);
    drain_one(2, 16'h1111, "R9 ch2 w0");
    drain_one(2, 16'h2222, "R9 ch2 w1");
    drain_one(2, 16'h3333, "R9 ch2 w2");
    chk("R9 ch2 empty", 32'(core_in_valid[2]), 32'h0);

    // R5: fill channel 1, overflow write dropped
    for (int i = 0; i < D; i++) bus_op(mk(ID, 1, 0, 0), 0, 16'h0100 + 16'(i), 1, '0, "");
    bus_op(mk(ID, 1, 1, 0), 1, '0, 1, 16'h0002, "R5 inbound status full");
    bus_op(mk(ID, 1, 0, 0), 0, 16'hDEAD, 1, '0, "");
    for (int i = 0; i < D; i++) drain_one(1, 16'h0100 + 16'(i), "R5 ch1 keep");
    chk("R5 overflow dropped", 32'(core_in_valid[1]), 32'h0);

    // R10 / R3 / R6: outbound channel 4
    core_push(4, 16'h4A01);
    core_push(4, 16'h4A02);
    core_push(4, 16'h4A03);
    bus_op(mk(ID, 4, 1, 1), 1, '0, 1, 16'h0000, "R4 outbound status busy");
    bus_op(mk(ID, 4, 0, 0), 1, '0, 1, 16'h4A01, "R3 read w0");
    bus_op(mk(ID, 4, 0, 0), 1, '0, 1, 16'h4A02, "R3 read w1");
    bus_op(mk(ID, 4, 0, 0), 1, '0, 1, 16'h4A03, "R3 read w2");
    bus_op(mk(ID, 4, 0, 0), 1, '0, 1, 16'h0000, "R6 empty read zero");
    bus_op(mk(ID, 4, 1, 1), 1, '0, 1, 16'h0001, "R6 outbound still empty");
    core_push(4, 16'h4A04);
    bus_op(mk(ID, 4, 0, 0), 1, '0, 1, 16'h4A04, "R6 pointer unmoved");

    // R10: outbound back-pressure on channel 7
    for (int i = 0; i < D; i++) core_push(7, 16'h7000 + 16'(i));
    chk("R10 ready low when full", 32'(core_out_ready[7]), 32'h0);
    bus_op(mk(ID, 7, 1, 1), 1, '0, 1, 16'h0002, "R10 outbound status full");
    bus_op(mk(ID, 7, 0, 0), 1, '0, 1, 16'h7000, "R10 first word");
    chk("R10 ready back", 32'(core_out_ready[7]), 32'h1);

    // R1: unclaimed accesses
    bus_op(mk(8'h5B, 3, 0, 0), 0, 16'hBAD1, 1, '0, "");
    bus_op(mk(ID, 3, 0, 0, 3'b000), 0, 16'hBAD2, 1, '0, "");
    bus_op(mk(ID, 3, 0, 0, 3'b101), 0, 16'hBAD3, 1, '0, "");
    chk("R1 foreign writes ignored", 32'(core_in_valid[3]), 32'h0);
    core_push(3, 16'h0B0B);
    bus_op(mk(8'h00, 3, 0, 0), 1, '0, 1, 16'h0000, "R1 foreign id read");
    bus_op(mk(ID, 3, 0, 0, 3'b011), 1, '0, 1, 16'h0000, "R1 wrong space read");
    bus_op(mk(ID, 3, 0, 0), 1, '0, 1, 16'h0B0B, "R1 word not popped");

    // R7: held strobes give one access
    bus_op(mk(ID, 5, 0, 0), 0, 16'h0777, 4, '0, "");
    drain_one(5, 16'h0777, "R7 held write");
    chk("R7 single push", 32'(core_in_valid[5]), 32'h0);
    core_push(6, 16'h0A01);
    core_push(6, 16'h0A02);
    bus_op(mk(ID, 6, 0, 0), 1, '0, 3, 16'h0A01, "R7 held read");
    bus_op(mk(ID, 6, 0, 0), 1, '0, 1, 16'h0A02, "R7 single pop");

    // R11: write into status space ignored
    bus_op(mk(ID, 0, 1, 0), 0, 16'hC0DE, 1, '0, "");
    bus_op(mk(ID, 0, 1, 1), 0, 16'hC0DE, 1, '0, "");
    chk("R11 status write ignored", 32'(core_in_valid[0]), 32'h0);
    bus_op(mk(ID, 0, 1, 0), 1, '0, 1, 16'h0001, "R11 inbound still empty");

    repeat (3) @(negedge clk);
    chk("R3 scoreboard drained", 32'(sb.size()), 32'h0);
    finish_run();
  end

endmodule